// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller with Vector Output

The block joins two eight-input priority resolvers into one sixteen-input interrupt source for a processor. Input lines 0 to 7 belong to the first (master) stage and lines 8 to 15 to the second (slave) stage: bit 3 of the line number picks the stage and bits 2:0 pick its pin. The slave's request does not reach the processor directly. It drives master pin 2, so a slave interrupt has to win arbitration on the master before the processor sees it.

When the processor acknowledges, the block returns an 8-bit vector one cycle later. In the normal case the master is marked in service and the vector is the master base plus the winning master pin. If the master winner is pin 2, the slave is acknowledged as well and the vector is formed from the slave base and the slave winner. When a stage has no valid winner at acknowledge time, that stage's base plus 7 is returned as a spurious vector.

Each stage has a base register, a mask register and a trigger-mode register that selects edge or level per pin. Each trigger-mode register has its own fixed write mask. The command decoding inside each stage is not part of this block. Only two of its results are exposed here: one end-of-interrupt strobe per stage, and register access through a small write/read port.

Top module: `pic_cascade`

## Requirements
- R1: After reset, intOut and vecValid are 0, both trigger-mode registers read 0, both mask registers read 0, and the master and slave base registers read 0x08 and 0x70.
- R2: With regSpace=1, regAddr[0]=0 selects the master trigger-mode register and regAddr[0]=1 selects the slave one. A write stores regData AND 0xF8 for the master and regData AND 0xDE for the slave.
- R3: With regSpace=0, regAddr[7] selects the stage (0 master, 1 slave) and regAddr[0] selects the base register (0) or the mask register (1). A base write stores regData AND 0xF8. A mask write stores regData unchanged. A write to one register leaves the others as they were.
- R4: A trigger-mode bit of 0 makes the pin edge-sensitive. A rising edge latches a request, and acknowledging it clears the request even while the line stays high. A bit of 1 makes the pin level-sensitive, so its request follows the line and comes back after end-of-interrupt while the line is still high. A master line that rises before clock edge k raises intOut after edge k+1.
- R5: Among the pending, unmasked pins of a stage, the lowest pin number wins. A set mask bit keeps a pin from requesting, but the pin's edge is still latched. A pin that is in service blocks requests from itself and from every higher-numbered pin.
- R6: vecValid is high in exactly the cycle after each cycle in which inta is high. For a master winner other than pin 2, vecOut is the master base plus the pin number.
- R7: The slave request acts as a level-sensitive request on master pin 2, and irqIn[2] has no effect. A slave line that rises before edge k raises intOut after edge k+2. A cascaded acknowledge returns the slave base plus the slave winner.
- R8: If the master winner is pin 2 at acknowledge but the slave has no winner, vecOut is the slave base plus 7.
- R9: If the master has no winner at acknowledge, vecOut is the master base plus 7, and no in-service state changes.
- R10: A high eoi[i] clears the lowest-numbered in-service bit of stage i (0 master, 1 slave), which unblocks lower-priority requests.
- R11: intOut is the master request delayed by one register. It falls one cycle after the acknowledge that removes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWr | input | 1 | Register write strobe |
| regSpace | input | 1 | 0 selects the stage registers, 1 selects the trigger-mode registers |
| regAddr | input | 8 | Register address: bit 7 selects the stage, bit 0 selects the register |
| regData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register that regSpace and regAddr select (combinational) |
| irqIn | input | 16 | Interrupt lines: 0-7 master, 8-15 slave |
| inta | input | 1 | Processor interrupt acknowledge, one cycle per acknowledge |
| eoi | input | 2 | End-of-interrupt strobes: bit 0 master, bit 1 slave |
| intOut | output | 1 | Registered interrupt request to the processor |
| vecOut | output | 8 | Vector returned for the last acknowledge |
| vecValid | output | 1 | vecOut is valid |

## Verification
Each result is checked in the cycle it is due:
- A master line raises intOut after the second clock edge following the change.
- A slave line raises intOut after the third edge, because the cascade adds one more register.
- The vector appears one edge after inta.
- intOut falls one edge after the acknowledge or end-of-interrupt that changes the request.

Inputs are driven on the falling edge and outputs are sampled on the next falling edge, after the counted number of rising edges. The bench checks intOut on both sides of each expected transition. This exposes a design with an extra or a missing register stage. The slave spurious case is timed exactly: the acknowledge falls in the single cycle in which master pin 2 still holds the old slave request after the slave line has dropped.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    VEC_MASTER = 2'd0,
    VEC_SLAVE  = 2'd1,
    VEC_SPUR_M = 2'd2,
    VEC_SPUR_S = 2'd3
  } vecSel_e;

  typedef struct packed {
    logic [1:0] wrBase;
    logic [1:0] wrMask;
    logic [1:0] wrTrig;
    logic [1:0] eoi;
    logic       ackMaster;
    logic       ackSlave;
    logic       loadVec;
    vecSel_e    vecSel;
  } strobe_t;

  localparam int CAS_PIN = 2;

endpackage

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int PINS = 8,
  localparam int IDW = $clog2(PINS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] lines,
  input  logic [PINS-1:0] trig,
  input  logic [PINS-1:0] mask,
  input  logic            ack,
  input  logic            eoi,
  output logic            req,
  output logic [IDW-1:0]  winId
);

  logic [PINS-1:0] irr, isr, lastLines, pending;
  logic            pValid, sValid;
  logic [IDW-1:0]  pWin, sWin;

  function automatic logic [IDW:0] lowest(input logic [PINS-1:0] v);
    lowest = '0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (v[i]) lowest = {1'b1, IDW'(i)};
    end
  endfunction

  always_comb begin
    pending         = irr & ~mask;
    {pValid, pWin}  = lowest(pending);
    {sValid, sWin}  = lowest(isr);
    req             = pValid && (!sValid || (pWin < sWin));
    winId           = pWin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr       <= '0;
      isr       <= '0;
      lastLines <= '0;
    end else begin
      lastLines <= lines;
      for (int i = 0; i < PINS; i++) begin
        if (trig[i]) begin
          irr[i] <= lines[i];
        end else begin
          irr[i] <= (lines[i] & ~lastLines[i]) |
                    (irr[i] & ~(ack && req && (winId == IDW'(i))));
        end
        if (ack && req && (winId == IDW'(i))) begin
          isr[i] <= 1'b1;
        end else if (eoi && sValid && (sWin == IDW'(i))) begin
          isr[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
#(
  parameter int PINS = 8,
  parameter int VW   = 8,
  localparam int IDW = $clog2(PINS)
) (
  input  logic           regWr,
  input  logic           regSpace,
  input  logic [VW-1:0]  regAddr,
  input  logic           inta,
  input  logic [1:0]     eoi,
  input  logic           masterReq,
  input  logic [IDW-1:0] masterWin,
  input  logic           slaveReq,
  output strobe_t        stb,
  output logic           rdCtl,
  output logic           rdLow
);

  logic unusedAddr;
  assign unusedAddr = ^regAddr[VW-2:1];

  assign rdCtl = regAddr[VW-1];
  assign rdLow = regAddr[0];

  always_comb begin
    stb        = '0;
    stb.vecSel = VEC_SPUR_M;
    stb.eoi    = eoi;
    if (regWr) begin
      if (regSpace) begin
        stb.wrTrig[regAddr[0]] = 1'b1;
      end else if (regAddr[0]) begin
        stb.wrMask[regAddr[VW-1]] = 1'b1;
      end else begin
        stb.wrBase[regAddr[VW-1]] = 1'b1;
      end
    end
    stb.loadVec = inta;
    if (masterReq) begin
      stb.ackMaster = inta;
      if (masterWin == IDW'(CAS_PIN)) begin
        stb.ackSlave = inta && slaveReq;
        stb.vecSel   = slaveReq ? VEC_SLAVE : VEC_SPUR_S;
      end else begin
        stb.vecSel   = VEC_MASTER;
      end
    end
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int             PINS       = 8,
  parameter int             VW         = 8,
  parameter logic [VW-1:0]  MBASE_RST  = 8'h08,
  parameter logic [VW-1:0]  SBASE_RST  = 8'h70,
  parameter logic [VW-1:0]  MTRIG_MASK = 8'hF8,
  parameter logic [VW-1:0]  STRIG_MASK = 8'hDE,
  localparam int            IDW        = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [VW-1:0]     wrData,
  input  logic [2*PINS-1:0] irqIn,
  input  logic              rdSpace,
  input  logic              rdCtl,
  input  logic              rdLow,
  output logic [VW-1:0]     rdData,
  output logic              intOut,
  output logic [VW-1:0]     vecOut,
  output logic              vecValid,
  output logic              masterReq,
  output logic [IDW-1:0]    masterWin,
  output logic              slaveReq
);

  localparam logic [VW-1:0]   BASE_MASK = ~VW'((1 << IDW) - 1);
  localparam logic [VW-1:0]   SPUR_OFS  = VW'(PINS - 1);
  localparam logic [PINS-1:0] CAS_BIT   = PINS'(1) << CAS_PIN;

  logic [VW-1:0]   baseReg [2];
  logic [VW-1:0]   maskReg [2];
  logic [VW-1:0]   trigReg [2];
  logic [PINS-1:0] linesC  [2];
  logic [PINS-1:0] trigEff [2];
  logic            reqC    [2];
  logic [IDW-1:0]  winC    [2];
  logic            ackC    [2];

  assign ackC[0] = stb.ackMaster;
  assign ackC[1] = stb.ackSlave;

  assign linesC[0]  = (irqIn[PINS-1:0] & ~CAS_BIT) | (reqC[1] ? CAS_BIT : '0);
  assign linesC[1]  = irqIn[2*PINS-1:PINS];
  assign trigEff[0] = trigReg[0][PINS-1:0] | CAS_BIT;
  assign trigEff[1] = trigReg[1][PINS-1:0];

  for (genvar c = 0; c < 2; c++) begin : g_stage
    localparam logic [VW-1:0] TRIG_MASK = (c == 0) ? MTRIG_MASK : STRIG_MASK;
    localparam logic [VW-1:0] BASE_RST  = (c == 0) ? MBASE_RST : SBASE_RST;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseReg[c] <= BASE_RST & BASE_MASK;
        maskReg[c] <= '0;
        trigReg[c] <= '0;
      end else begin
        if (stb.wrBase[c]) baseReg[c] <= wrData & BASE_MASK;
        if (stb.wrMask[c]) maskReg[c] <= wrData;
        if (stb.wrTrig[c]) trigReg[c] <= wrData & TRIG_MASK;
      end
    end

    irq_resolver #(.PINS(PINS)) u_res (
      .clk   (clk),
      .rstN  (rstN),
      .lines (linesC[c]),
      .trig  (trigEff[c]),
      .mask  (maskReg[c][PINS-1:0]),
      .ack   (ackC[c]),
      .eoi   (stb.eoi[c]),
      .req   (reqC[c]),
      .winId (winC[c])
    );
  end

  assign masterReq = reqC[0];
  assign masterWin = winC[0];
  assign slaveReq  = reqC[1];

  always_comb begin
    if (rdSpace) rdData = trigReg[rdLow];
    else         rdData = rdLow ? maskReg[rdCtl] : baseReg[rdCtl];
  end

  logic [VW-1:0] vecNext;
  always_comb begin
    unique case (stb.vecSel)
      VEC_MASTER: vecNext = baseReg[0] + VW'(winC[0]);
      VEC_SLAVE:  vecNext = baseReg[1] + VW'(winC[1]);
      VEC_SPUR_M: vecNext = baseReg[0] + SPUR_OFS;
      default:    vecNext = baseReg[1] + SPUR_OFS;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOut   <= 1'b0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      intOut   <= reqC[0];
      vecValid <= stb.loadVec;
      if (stb.loadVec) vecOut <= vecNext;
    end
  end

endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
#(
  parameter int            PINS       = 8,
  parameter int            VW         = 8,
  parameter logic [VW-1:0] MBASE_RST  = 8'h08,
  parameter logic [VW-1:0] SBASE_RST  = 8'h70,
  parameter logic [VW-1:0] MTRIG_MASK = 8'hF8,
  parameter logic [VW-1:0] STRIG_MASK = 8'hDE,
  localparam int           IDW        = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regSpace,
  input  logic [VW-1:0]     regAddr,
  input  logic [VW-1:0]     regData,
  output logic [VW-1:0]     rdData,
  input  logic [2*PINS-1:0] irqIn,
  input  logic              inta,
  input  logic [1:0]        eoi,
  output logic              intOut,
  output logic [VW-1:0]     vecOut,
  output logic              vecValid
);

  strobe_t        stb;
  logic           masterReq, slaveReq, rdCtl, rdLow;
  logic [IDW-1:0] masterWin;

  pic_control #(.PINS(PINS), .VW(VW)) u_ctl (
    .regWr     (regWr),
    .regSpace  (regSpace),
    .regAddr   (regAddr),
    .inta      (inta),
    .eoi       (eoi),
    .masterReq (masterReq),
    .masterWin (masterWin),
    .slaveReq  (slaveReq),
    .stb       (stb),
    .rdCtl     (rdCtl),
    .rdLow     (rdLow)
  );

  pic_datapath #(
    .PINS(PINS), .VW(VW), .MBASE_RST(MBASE_RST), .SBASE_RST(SBASE_RST),
    .MTRIG_MASK(MTRIG_MASK), .STRIG_MASK(STRIG_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regData),
    .irqIn     (irqIn),
    .rdSpace   (regSpace),
    .rdCtl     (rdCtl),
    .rdLow     (rdLow),
    .rdData    (rdData),
    .intOut    (intOut),
    .vecOut    (vecOut),
    .vecValid  (vecValid),
    .masterReq (masterReq),
    .masterWin (masterWin),
    .slaveReq  (slaveReq)
  );

endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
  parameter int            PINS       = 8,
  parameter int            VW         = 8,
  parameter logic [VW-1:0] MTRIG_MASK = 8'hF8,
  parameter logic [VW-1:0] STRIG_MASK = 8'hDE
) (
  input logic          clk,
  input logic          rstN,
  input logic          regSpace,
  input logic [VW-1:0] regAddr,
  input logic [VW-1:0] rdData,
  input logic          inta,
  input logic          vecValid
);

  localparam int IDW = $clog2(PINS);

  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    inta |=> vecValid);

  p_no_vec_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inta |=> !vecValid);

  p_master_trig_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSpace && !regAddr[0]) |-> ((rdData & ~MTRIG_MASK) == '0));

  p_slave_trig_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSpace && regAddr[0]) |-> ((rdData & ~STRIG_MASK) == '0));

  p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!regSpace && !regAddr[0]) |-> (rdData[IDW-1:0] == '0));

endmodule

bind pic_cascade pic_cascade_chk #(
  .PINS(PINS), .VW(VW), .MTRIG_MASK(MTRIG_MASK), .STRIG_MASK(STRIG_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSpace (regSpace),
  .regAddr  (regAddr),
  .rdData   (rdData),
  .inta     (inta),
  .vecValid (vecValid)
);

// File: tb/sim_pic_cascade.sv
module sim_pic_cascade;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regSpace = 1'b0;
  logic [7:0]  regAddr = '0, regData = '0;
  logic [7:0]  rdData;
  logic [15:0] irqIn = '0;
  logic        inta = 1'b0;
  logic [1:0]  eoi = '0;
  logic        intOut, vecValid;
  logic [7:0]  vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pic_cascade u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSpace(regSpace),
    .regAddr(regAddr), .regData(regData), .rdData(rdData), .irqIn(irqIn),
    .inta(inta), .eoi(eoi), .intOut(intOut), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  // {space, addr, write data, expected read}
  localparam logic [24:0] REG_TBL [8] = '{
    {1'b1, 8'h00, 8'hFF, 8'hF8},  // R2 master trigger mask
    {1'b1, 8'h01, 8'hFF, 8'hDE},  // R2 slave trigger mask
    {1'b1, 8'h01, 8'h21, 8'h00},  // R2 slave bits 0 and 5 dropped
    {1'b1, 8'h00, 8'h07, 8'h00},  // R2 master low bits dropped
    {1'b0, 8'h00, 8'h2B, 8'h28},  // R3 master base aligned
    {1'b0, 8'h80, 8'h77, 8'h70},  // R3 slave base aligned
    {1'b0, 8'h81, 8'h5A, 8'h5A},  // R3 slave mask
    {1'b0, 8'h81, 8'h00, 8'h00}   // R3 slave mask cleared
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic sp, logic [7:0] a, logic [7:0] d);
    regSpace = sp; regAddr = a; regData = d; regWr = 1'b1;
    tick();
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic sp, logic [7:0] a, output logic [7:0] d);
    regSpace = sp; regAddr = a;
    #1 d = rdData;
  endtask

  task automatic ack(string tag, logic [7:0] exp);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    chk({tag, " valid"}, {7'd0, vecValid}, 8'h01);
    chk({tag, " vector"}, vecOut, exp);
  endtask

  task automatic pulseEoi(logic [1:0] e);
    eoi = e;
    tick();
    eoi = 2'b00;
  endtask

  initial begin
    logic [7:0] rd;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk("R1 intOut", {7'd0, intOut}, 8'h00);
    chk("R1 vecValid", {7'd0, vecValid}, 8'h00);
    rdReg(1'b1, 8'h00, rd); chk("R1 master trig", rd, 8'h00);
    rdReg(1'b1, 8'h01, rd); chk("R1 slave trig", rd, 8'h00);
    rdReg(1'b0, 8'h00, rd); chk("R1 master base", rd, 8'h08);
    rdReg(1'b0, 8'h80, rd); chk("R1 slave base", rd, 8'h70);
    rdReg(1'b0, 8'h01, rd); chk("R1 master mask", rd, 8'h00);
    rdReg(1'b0, 8'h81, rd); chk("R1 slave mask", rd, 8'h00);

    // R2 / R3 table walk
    for (int i = 0; i < 8; i++) begin
      wrReg(REG_TBL[i][24], REG_TBL[i][23:16], REG_TBL[i][15:8]);
      rdReg(REG_TBL[i][24], REG_TBL[i][23:16], rd);
      chk($sformatf("R2/R3 table entry %0d", i), rd, REG_TBL[i][7:0]);
    end
    rdReg(1'b0, 8'h80, rd); chk("R3 slave base kept", rd, 8'h70);
    rdReg(1'b0, 8'h00, rd); chk("R3 master base kept", rd, 8'h28);

    // R4 edge timing, R6 vector, R11 registered output
    irqIn[5] = 1'b1;
    tick();
    chk("R4 intOut after 1 edge", {7'd0, intOut}, 8'h00);
    tick();
    chk("R4 intOut after 2 edges", {7'd0, intOut}, 8'h01);
    ack("R6 master pin 5", 8'h2D);
    chk("R11 intOut lags ack", {7'd0, intOut}, 8'h01);
    tick();
    chk("R11 intOut falls", {7'd0, intOut}, 8'h00);
    chk("R6 vecValid one cycle", {7'd0, vecValid}, 8'h00);
    pulseEoi(2'b01);
    tick(); tick();
    chk("R4 edge cleared by ack", {7'd0, intOut}, 8'h00);
    irqIn[5] = 1'b0;
    tick();

    // R5 priority and in-service blocking, R10 eoi
    irqIn[6] = 1'b1; irqIn[3] = 1'b1;
    tick(); tick();
    ack("R5 lowest pin wins", 8'h2B);
    tick(); tick();
    chk("R5 in-service blocks pin 6", {7'd0, intOut}, 8'h00);
    pulseEoi(2'b01);
    tick();
    chk("R10 eoi unblocks pin 6", {7'd0, intOut}, 8'h01);
    ack("R10 pin 6 after eoi", 8'h2E);
    pulseEoi(2'b01);
    irqIn[6] = 1'b0; irqIn[3] = 1'b0;
    tick();

    // R5 mask, R9 master spurious
    wrReg(1'b0, 8'h01, 8'h10);
    irqIn[4] = 1'b1;
    tick(); tick(); tick();
    chk("R5 masked pin silent", {7'd0, intOut}, 8'h00);
    ack("R9 master spurious", 8'h2F);
    wrReg(1'b0, 8'h01, 8'h00);
    tick();
    chk("R5 latched edge after unmask", {7'd0, intOut}, 8'h01);
    ack("R5 unmasked pin 4", 8'h2C);
    pulseEoi(2'b01);
    irqIn[4] = 1'b0;
    tick();

    // R4 level-sensitive pin 6
    wrReg(1'b1, 8'h00, 8'h40);
    irqIn[6] = 1'b1;
    tick(); tick();
    ack("R4 level pin 6", 8'h2E);
    pulseEoi(2'b01);
    tick();
    chk("R4 level request returns", {7'd0, intOut}, 8'h01);
    irqIn[6] = 1'b0;
    tick(); tick();
    chk("R4 level request follows line", {7'd0, intOut}, 8'h00);
    wrReg(1'b1, 8'h00, 8'h00);

    // R7 cascade
    irqIn[2] = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R7 irqIn[2] ignored", {7'd0, intOut}, 8'h00);
    irqIn[2] = 1'b0;
    irqIn[9] = 1'b1;
    tick(); tick();
    chk("R7 slave after 2 edges", {7'd0, intOut}, 8'h00);
    tick();
    chk("R7 slave after 3 edges", {7'd0, intOut}, 8'h01);
    ack("R7 cascaded vector", 8'h71);
    pulseEoi(2'b11);
    irqIn[9] = 1'b0;
    tick(); tick();

    // R8 slave spurious
    wrReg(1'b1, 8'h01, 8'h02);
    irqIn[9] = 1'b1;
    tick(); tick(); tick();
    chk("R8 slave level request", {7'd0, intOut}, 8'h01);
    irqIn[9] = 1'b0;
    tick();
    ack("R8 slave spurious", 8'h77);
    pulseEoi(2'b01);
    tick(); tick();
    chk("R8 request gone", {7'd0, intOut}, 8'h00);

    // R9 nothing pending
    ack("R9 idle spurious", 8'h2F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule